// File: doc/BRIEF.md
# Cipher Control Register File

This block sits on the cipher side of a 32-bit control bus and turns single-cycle register writes and read requests into the parameter set that a block-cipher engine consumes. It holds the key words, the key length selector, the IV words, the direction (encrypt or decrypt) and bypass selectors, the AAD and payload lengths, and two buffer start addresses. It also returns the engine's busy flags, the captured authentication tag and a fixed version word. In addition, it gives the bus word-level access to an input buffer memory and an output buffer memory. Both memories are external and are reached through their own ports.

The decode works in two levels. The upper address bits choose an area: the input memory, the output memory, or the internal registers. The lower bits then choose a word inside that area. A write to the payload-length register also launches the engine with a one-cycle start pulse. A write to the key-load register sends a one-cycle key strobe. A read request is answered two cycles later by a one-cycle valid strobe that carries the data.

Top module: `cipher_ctrl_regfile`

## Requirements
- R1: Address bits [15:11] select the area. The value 5'b00100 selects the input memory and 5'b01000 selects the output memory. Every other value selects the internal registers, so a write to 0x6004 updates the output start address register.
- R2: Inside an area, address bits [10:2] give the word index. That index is driven on both memory address ports, so a write to 0x2004 lands in input memory word 1 and a write to 0x4008 lands in output memory word 2.
- R3: A write to a memory area drives the 4-bit byte enable (bit n covers data bits [8n+7:8n]) onto that memory's byte-write enables only. The other memory's enables stay zero, and both stay zero for register writes.
- R4: A read request sampled at clock edge N produces `reg_rd_valid` high for exactly one cycle after edge N+1, together with the data. For a memory area the data is that memory's read word.
- R5: Register writes store the whole word and drive the matching output, and each register reads back. The registers are: 0x00 input start address (bits [10:4]), 0x04 output start address (bits [10:4]), 0x08 AAD length [15:0], 0x10 decrypt enable bit0, 0x14 bypass bit0, 0x18 key size bit0 (1 = 256-bit key, 0 = 128-bit key), 0x20..0x3C key words (0x20 drives key bits [31:0]) and 0x40..0x48 IV words (0x40 drives IV bits [31:0]).
- R6: A write to 0x0C stores the payload length [15:0] and raises `start` for exactly one cycle, in the cycle after the write edge.
- R7: A read of 0x0C returns bit1 = `key_busy` and bit0 = `busy`, with all other bits zero.
- R8: A write to 0x1C raises `key_load` for exactly one cycle, in the cycle after the write edge. It stores nothing, and a read of 0x1C returns zero.
- R9: When `tag_valid` is high, `tag_in` is captured. Reads of 0x50, 0x54, 0x58 and 0x5C return tag bits [31:0], [63:32], [95:64] and [127:96].
- R10: A read of 0x60 returns the VERSION parameter (default 32'h0002_0100).
- R11: A read of an unmapped register offset returns zero, and a write to one changes no output.
- R12: After reset every stored register and every tag word is zero, and `start`, `key_load`, `reg_rd_valid` and both memory write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cipher-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Single-cycle write strobe |
| reg_addr | input | 16 | Byte address of the access |
| reg_wr_data | input | 32 | Write data |
| reg_wr_be | input | 4 | Write byte enables |
| reg_rd_req | input | 1 | Single-cycle read request |
| reg_rd_valid | output | 1 | Read data valid strobe |
| reg_rd_data | output | 32 | Read data |
| in_mem_addr | output | 9 | Input memory word address |
| in_mem_we | output | 4 | Input memory byte-write enables |
| in_mem_wdata | output | 32 | Input memory write data |
| in_mem_rdata | input | 32 | Input memory read data (one-cycle latency) |
| out_mem_addr | output | 9 | Output memory word address |
| out_mem_we | output | 4 | Output memory byte-write enables |
| out_mem_wdata | output | 32 | Output memory write data |
| out_mem_rdata | input | 32 | Output memory read data (one-cycle latency) |
| in_base_addr | output | 7 | Input buffer start address |
| out_base_addr | output | 7 | Output buffer start address |
| aad_len | output | 16 | AAD length |
| data_len | output | 16 | Payload length |
| decrypt_en | output | 1 | 1 = decrypt, 0 = encrypt |
| bypass_en | output | 1 | Bypass selector |
| key_size | output | 1 | 1 = 256-bit key, 0 = 128-bit key |
| key_out | output | 256 | Key words, word 0 lowest |
| iv_out | output | 96 | IV words, word 0 lowest |
| start | output | 1 | One-cycle engine start pulse |
| key_load | output | 1 | One-cycle key load strobe |
| busy | input | 1 | Engine busy flag |
| key_busy | input | 1 | Key expansion busy flag |
| tag_valid | input | 1 | Tag capture strobe |
| tag_in | input | 128 | Tag from the engine |

## Verification
The assertions assume that the bus presents a write and a read request as single-cycle strobes with the address held steady during that cycle. They also assume that the memories answer a read one cycle after the address appears. The pulse checks assume that a strobe has a write behind it. The bench drives each strobe for exactly one cycle and separates consecutive accesses by at least one idle cycle. Its memory model registers its read word on every edge, which matches the one-cycle latency the read path expects.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   typedef enum logic [1:0] {
      AREA_REG = 2'd0,
      AREA_IN  = 2'd1,
      AREA_OUT = 2'd2
   } area_e;

   localparam int unsigned WSEL_W = 9;
   localparam int unsigned AREA_W = 5;

   localparam logic [AREA_W-1:0] SEL_IN  = 5'b00100;
   localparam logic [AREA_W-1:0] SEL_OUT = 5'b01000;

   localparam logic [WSEL_W-1:0] W_IN_BASE  = 9'd0;
   localparam logic [WSEL_W-1:0] W_OUT_BASE = 9'd1;
   localparam logic [WSEL_W-1:0] W_AAD      = 9'd2;
   localparam logic [WSEL_W-1:0] W_DLEN     = 9'd3;
   localparam logic [WSEL_W-1:0] W_DEC      = 9'd4;
   localparam logic [WSEL_W-1:0] W_BYP      = 9'd5;
   localparam logic [WSEL_W-1:0] W_KSIZE    = 9'd6;
   localparam logic [WSEL_W-1:0] W_KLOAD    = 9'd7;
   localparam logic [WSEL_W-1:0] W_KEY0     = 9'd8;
   localparam logic [WSEL_W-1:0] W_IV0      = 9'd16;
   localparam logic [WSEL_W-1:0] W_TAG0     = 9'd20;
   localparam logic [WSEL_W-1:0] W_VER      = 9'd24;
endpackage

// File: rtl/ccr_area_decode.sv
module ccr_area_decode
   import ccr_pkg::*;
#(
   parameter int unsigned ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output area_e             area,
   output logic [WSEL_W-1:0] word
);
   localparam int unsigned HI_LSB = ADDR_W - AREA_W;

   logic [AREA_W-1:0] hi;

   assign hi   = addr[ADDR_W-1:HI_LSB];
   assign word = addr[WSEL_W+1:2];

   always_comb begin
      unique case (hi)
         SEL_IN:  area = AREA_IN;
         SEL_OUT: area = AREA_OUT;
         default: area = AREA_REG;
      endcase
   end
endmodule

// File: rtl/ccr_param_regs.sv
module ccr_param_regs
   import ccr_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE_W    = 7,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned KEY_WORDS = 8,
   parameter int unsigned IV_WORDS  = 3,
   parameter int unsigned TAG_WORDS = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  area_e                         area,
   input  logic [WSEL_W-1:0]             word,
   input  logic [DATA_W-1:0]             wr_data,
   input  logic                          tag_valid,
   input  logic [TAG_WORDS*DATA_W-1:0]   tag_in,
   output logic [BASE_W-1:0]             in_base,
   output logic [BASE_W-1:0]             out_base,
   output logic [LEN_W-1:0]              aad_len,
   output logic [LEN_W-1:0]              data_len,
   output logic                          dec_en,
   output logic                          byp_en,
   output logic                          key_size,
   output logic [KEY_WORDS*DATA_W-1:0]   key_flat,
   output logic [IV_WORDS*DATA_W-1:0]    iv_flat,
   output logic [TAG_WORDS*DATA_W-1:0]   tag_flat,
   output logic                          start,
   output logic                          key_load
);
   logic wr_reg;
   assign wr_reg = wr_en && (area == AREA_REG);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_base  <= '0;
         out_base <= '0;
         aad_len  <= '0;
         data_len <= '0;
         dec_en   <= 1'b0;
         byp_en   <= 1'b0;
         key_size <= 1'b0;
         start    <= 1'b0;
         key_load <= 1'b0;
      end else begin
         start    <= 1'b0;
         key_load <= 1'b0;
         if (wr_reg) begin
            case (word)
               W_IN_BASE:  in_base  <= wr_data[BASE_W+3:4];
               W_OUT_BASE: out_base <= wr_data[BASE_W+3:4];
               W_AAD:      aad_len  <= wr_data[LEN_W-1:0];
               W_DLEN: begin
                  data_len <= wr_data[LEN_W-1:0];
                  start    <= 1'b1;
               end
               W_DEC:      dec_en   <= wr_data[0];
               W_BYP:      byp_en   <= wr_data[0];
               W_KSIZE:    key_size <= wr_data[0];
               W_KLOAD:    key_load <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   // one storage word per key slot
   for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
      always_ff @(posedge clk) begin
         if (!rst_n)
            key_flat[k*DATA_W +: DATA_W] <= '0;
         else if (wr_reg && (word == W_KEY0 + WSEL_W'(k)))
            key_flat[k*DATA_W +: DATA_W] <= wr_data;
      end
   end

   for (genvar v = 0; v < IV_WORDS; v++) begin : g_iv
      always_ff @(posedge clk) begin
         if (!rst_n)
            iv_flat[v*DATA_W +: DATA_W] <= '0;
         else if (wr_reg && (word == W_IV0 + WSEL_W'(v)))
            iv_flat[v*DATA_W +: DATA_W] <= wr_data;
      end
   end

   for (genvar t = 0; t < TAG_WORDS; t++) begin : g_tag
      always_ff @(posedge clk) begin
         if (!rst_n)
            tag_flat[t*DATA_W +: DATA_W] <= '0;
         else if (tag_valid)
            tag_flat[t*DATA_W +: DATA_W] <= tag_in[t*DATA_W +: DATA_W];
      end
   end

   // R6 / R8: each strobe is one cycle wide unless the write repeats
   p_start_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!start || $past(wr_reg)));
   p_kload_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> (!key_load || $past(wr_reg)));
endmodule

// File: rtl/ccr_read_path.sv
module ccr_read_path
   import ccr_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE_W    = 7,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned KEY_WORDS = 8,
   parameter int unsigned IV_WORDS  = 3,
   parameter int unsigned TAG_WORDS = 4,
   parameter logic [31:0] VERSION   = 32'h0002_0100
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_req,
   input  area_e                         area,
   input  logic [WSEL_W-1:0]             word,
   input  logic [BASE_W-1:0]             in_base,
   input  logic [BASE_W-1:0]             out_base,
   input  logic [LEN_W-1:0]              aad_len,
   input  logic                          dec_en,
   input  logic                          byp_en,
   input  logic                          key_size,
   input  logic [KEY_WORDS*DATA_W-1:0]   key_flat,
   input  logic [IV_WORDS*DATA_W-1:0]    iv_flat,
   input  logic [TAG_WORDS*DATA_W-1:0]   tag_flat,
   input  logic                          busy,
   input  logic                          key_busy,
   input  logic [DATA_W-1:0]             in_rdata,
   input  logic [DATA_W-1:0]             out_rdata,
   output logic                          rd_valid,
   output logic [DATA_W-1:0]             rd_data
);
   logic              req_q;
   area_e             area_q;
   logic [WSEL_W-1:0] word_q;
   logic [DATA_W-1:0] reg_val;
   logic [DATA_W-1:0] area_val;

   // stage 1: capture the request and its decoded address
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         area_q <= AREA_REG;
         word_q <= '0;
      end else begin
         req_q <= rd_req;
         if (rd_req) begin
            area_q <= area;
            word_q <= word;
         end
      end
   end

   // level one: word select inside the register area
   always_comb begin
      reg_val = '0;
      case (word_q)
         W_IN_BASE:  reg_val[BASE_W+3:4] = in_base;
         W_OUT_BASE: reg_val[BASE_W+3:4] = out_base;
         W_AAD:      reg_val[LEN_W-1:0]  = aad_len;
         W_DLEN:     reg_val[1:0]        = {key_busy, busy};
         W_DEC:      reg_val[0]          = dec_en;
         W_BYP:      reg_val[0]          = byp_en;
         W_KSIZE:    reg_val[0]          = key_size;
         W_VER:      reg_val             = VERSION;
         default: begin
            for (int k = 0; k < KEY_WORDS; k++)
               if (word_q == W_KEY0 + WSEL_W'(k)) reg_val = key_flat[k*DATA_W +: DATA_W];
            for (int v = 0; v < IV_WORDS; v++)
               if (word_q == W_IV0 + WSEL_W'(v)) reg_val = iv_flat[v*DATA_W +: DATA_W];
            for (int t = 0; t < TAG_WORDS; t++)
               if (word_q == W_TAG0 + WSEL_W'(t)) reg_val = tag_flat[t*DATA_W +: DATA_W];
         end
      endcase
   end

   // level two: area select
   always_comb begin
      unique case (area_q)
         AREA_IN:  area_val = in_rdata;
         AREA_OUT: area_val = out_rdata;
         default:  area_val = reg_val;
      endcase
   end

   // stage 2: valid strobe with data
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_q;
         if (req_q) rd_data <= area_val;
      end
   end

   p_valid_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(rd_req, 2));
endmodule

// File: rtl/cipher_ctrl_regfile.sv
module cipher_ctrl_regfile
   import ccr_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned BASE_W    = 7,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned KEY_WORDS = 8,
   parameter int unsigned IV_WORDS  = 3,
   parameter int unsigned TAG_WORDS = 4,
   parameter logic [31:0] VERSION   = 32'h0002_0100
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        reg_wr_en,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wr_data,
   input  logic [DATA_W/8-1:0]         reg_wr_be,
   input  logic                        reg_rd_req,
   output logic                        reg_rd_valid,
   output logic [DATA_W-1:0]           reg_rd_data,
   output logic [WSEL_W-1:0]           in_mem_addr,
   output logic [DATA_W/8-1:0]         in_mem_we,
   output logic [DATA_W-1:0]           in_mem_wdata,
   input  logic [DATA_W-1:0]           in_mem_rdata,
   output logic [WSEL_W-1:0]           out_mem_addr,
   output logic [DATA_W/8-1:0]         out_mem_we,
   output logic [DATA_W-1:0]           out_mem_wdata,
   input  logic [DATA_W-1:0]           out_mem_rdata,
   output logic [BASE_W-1:0]           in_base_addr,
   output logic [BASE_W-1:0]           out_base_addr,
   output logic [LEN_W-1:0]            aad_len,
   output logic [LEN_W-1:0]            data_len,
   output logic                        decrypt_en,
   output logic                        bypass_en,
   output logic                        key_size,
   output logic [KEY_WORDS*DATA_W-1:0] key_out,
   output logic [IV_WORDS*DATA_W-1:0]  iv_out,
   output logic                        start,
   output logic                        key_load,
   input  logic                        busy,
   input  logic                        key_busy,
   input  logic                        tag_valid,
   input  logic [TAG_WORDS*DATA_W-1:0] tag_in
);
   localparam int unsigned BE_W = DATA_W / 8;

   if (ADDR_W != WSEL_W + AREA_W + 2) begin : g_bad_addr
      $error("ADDR_W must equal word-select width plus area width plus 2");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32");
   end
   if (BASE_W + 4 > DATA_W || LEN_W > DATA_W) begin : g_bad_field
      $error("field does not fit in a data word");
   end
   if (KEY_WORDS > 8 || IV_WORDS > 4 || TAG_WORDS > 4) begin : g_bad_count
      $error("word count exceeds its register window");
   end

   area_e             area;
   logic [WSEL_W-1:0] word;
   logic [TAG_WORDS*DATA_W-1:0] tag_flat;

   ccr_area_decode #(.ADDR_W(ADDR_W)) i_dec (
      .addr (reg_addr),
      .area (area),
      .word (word)
   );

   assign in_mem_addr   = word;
   assign out_mem_addr  = word;
   assign in_mem_wdata  = reg_wr_data;
   assign out_mem_wdata = reg_wr_data;
   assign in_mem_we     = (reg_wr_en && area == AREA_IN)  ? reg_wr_be : '0;
   assign out_mem_we    = (reg_wr_en && area == AREA_OUT) ? reg_wr_be : '0;

   ccr_param_regs #(
      .DATA_W(DATA_W), .BASE_W(BASE_W), .LEN_W(LEN_W),
      .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .TAG_WORDS(TAG_WORDS)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .area(area), .word(word),
      .wr_data(reg_wr_data), .tag_valid(tag_valid), .tag_in(tag_in),
      .in_base(in_base_addr), .out_base(out_base_addr), .aad_len(aad_len),
      .data_len(data_len), .dec_en(decrypt_en), .byp_en(bypass_en),
      .key_size(key_size), .key_flat(key_out), .iv_flat(iv_out),
      .tag_flat(tag_flat), .start(start), .key_load(key_load)
   );

   ccr_read_path #(
      .DATA_W(DATA_W), .BASE_W(BASE_W), .LEN_W(LEN_W),
      .KEY_WORDS(KEY_WORDS), .IV_WORDS(IV_WORDS), .TAG_WORDS(TAG_WORDS),
      .VERSION(VERSION)
   ) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_req(reg_rd_req), .area(area), .word(word),
      .in_base(in_base_addr), .out_base(out_base_addr), .aad_len(aad_len),
      .dec_en(decrypt_en), .byp_en(bypass_en), .key_size(key_size),
      .key_flat(key_out), .iv_flat(iv_out), .tag_flat(tag_flat),
      .busy(busy), .key_busy(key_busy),
      .in_rdata(in_mem_rdata), .out_rdata(out_mem_rdata),
      .rd_valid(reg_rd_valid), .rd_data(reg_rd_data)
   );

   // R3: never both memories in one write, and only when a write is presented
   p_mem_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !((|in_mem_we) && (|out_mem_we)));
   p_mem_we_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|in_mem_we) || (|out_mem_we)) |-> reg_wr_en);
   // R6 / R8: pulses follow a bus write
   p_start_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> $past(reg_wr_en));
   p_kload_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |-> $past(reg_wr_en));
   // R4: a valid strobe needs a request two cycles back
   p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_valid |-> $past(reg_rd_req, 2));
   // R1: a register-area write leaves both memories untouched
   p_reg_area_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_addr[ADDR_W-1:ADDR_W-AREA_W] != SEL_IN
                 && reg_addr[ADDR_W-1:ADDR_W-AREA_W] != SEL_OUT)
      |-> (in_mem_we == '0 && out_mem_we == '0));
endmodule

// File: tb/test_cipher_ctrl_regfile.sv
`timescale 1ns/1ps
module test_cipher_ctrl_regfile;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr_en = 1'b0;
   logic [15:0]  reg_addr = '0;
   logic [31:0]  reg_wr_data = '0;
   logic [3:0]   reg_wr_be = '0;
   logic         reg_rd_req = 1'b0;
   logic         reg_rd_valid;
   logic [31:0]  reg_rd_data;
   logic [8:0]   in_mem_addr, out_mem_addr;
   logic [3:0]   in_mem_we, out_mem_we;
   logic [31:0]  in_mem_wdata, out_mem_wdata;
   logic [31:0]  in_mem_rdata = '0, out_mem_rdata = '0;
   logic [6:0]   in_base_addr, out_base_addr;
   logic [15:0]  aad_len, data_len;
   logic         decrypt_en, bypass_en, key_size, start, key_load;
   logic [255:0] key_out;
   logic [95:0]  iv_out;
   logic         busy = 1'b0, key_busy = 1'b0, tag_valid = 1'b0;
   logic [127:0] tag_in = '0;

   int checks = 0;
   int errors = 0;

   logic [31:0] in_ram  [512];
   logic [31:0] out_ram [512];

   always #2 clk = ~clk;

   always @(posedge clk) begin
      for (int b = 0; b < 4; b++) begin
         if (in_mem_we[b])  in_ram[in_mem_addr][8*b +: 8]   <= in_mem_wdata[8*b +: 8];
         if (out_mem_we[b]) out_ram[out_mem_addr][8*b +: 8] <= out_mem_wdata[8*b +: 8];
      end
      in_mem_rdata  <= in_ram[in_mem_addr];
      out_mem_rdata <= out_ram[out_mem_addr];
   end

   cipher_ctrl_regfile i_cipher_ctrl_regfile (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wr_data(reg_wr_data), .reg_wr_be(reg_wr_be), .reg_rd_req(reg_rd_req),
      .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
      .in_mem_addr(in_mem_addr), .in_mem_we(in_mem_we), .in_mem_wdata(in_mem_wdata),
      .in_mem_rdata(in_mem_rdata), .out_mem_addr(out_mem_addr), .out_mem_we(out_mem_we),
      .out_mem_wdata(out_mem_wdata), .out_mem_rdata(out_mem_rdata),
      .in_base_addr(in_base_addr), .out_base_addr(out_base_addr),
      .aad_len(aad_len), .data_len(data_len), .decrypt_en(decrypt_en),
      .bypass_en(bypass_en), .key_size(key_size), .key_out(key_out), .iv_out(iv_out),
      .start(start), .key_load(key_load), .busy(busy), .key_busy(key_busy),
      .tag_valid(tag_valid), .tag_in(tag_in)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   // returns at the negedge just after the write edge
   task automatic bus_write(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d; reg_wr_be = be;
      @(negedge clk);
      reg_wr_en = 1'b0; reg_wr_be = '0;
   endtask

   task automatic bus_read(input string req, input logic [15:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd_req = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd_req = 1'b0;
      check({req, " valid low one cycle after request"}, {31'b0, reg_rd_valid}, 32'd0);
      @(negedge clk);
      check({req, " valid high two cycles after request"}, {31'b0, reg_rd_valid}, 32'd1);
      d = reg_rd_data;
   endtask

   task automatic t_reset();
      check("R12 in_base", {25'b0, in_base_addr}, 32'd0);
      check("R12 data_len", {16'b0, data_len}, 32'd0);
      check("R12 key", key_out[31:0] | key_out[255:224], 32'd0);
      check("R12 pulses", {28'b0, start, key_load, reg_rd_valid, |in_mem_we}, 32'd0);
   endtask

   task automatic t_areas();
      logic [31:0] d;
      in_ram[1] = 32'h0; out_ram[1] = 32'h0;
      bus_write(16'h2004, 32'hCAFE_0001, 4'hF);
      check("R2 input word 1 written", in_ram[1], 32'hCAFE_0001);
      check("R1 output memory untouched", out_ram[1], 32'h0);
      bus_write(16'h4008, 32'hBEEF_0002, 4'hF);
      check("R2 output word 2 written", out_ram[2], 32'hBEEF_0002);
      bus_write(16'h6004, 32'h0000_0550, 4'hF);
      check("R1 other area goes to registers", {25'b0, out_base_addr}, 32'h55);
      check("R1 other area leaves input word 1", in_ram[1], 32'hCAFE_0001);
      bus_read("R4 input memory", 16'h2004, d);
      check("R4 input memory data", d, 32'hCAFE_0001);
      bus_read("R4 output memory", 16'h4008, d);
      check("R4 output memory data", d, 32'hBEEF_0002);
      @(negedge clk);
      check("R4 valid single cycle", {31'b0, reg_rd_valid}, 32'd0);
   endtask

   task automatic t_bytes();
      bus_write(16'h2010, 32'hAAAA_AAAA, 4'hF);
      bus_write(16'h2010, 32'h1122_5544, 4'b0010);
      check("R3 single byte store", in_ram[4], 32'hAAAA_55AA);
      bus_write(16'h2010, 32'h7788_0000, 4'b1100);
      check("R3 halfword store", in_ram[4], 32'h7788_55AA);
   endtask

   task automatic t_params();
      logic [31:0] d;
      bus_write(16'h0000, 32'h0000_07F0, 4'hF);
      check("R5 in_base", {25'b0, in_base_addr}, 32'h7F);
      bus_write(16'h0008, 32'h0000_0123, 4'hF);
      check("R5 aad_len", {16'b0, aad_len}, 32'h123);
      bus_write(16'h0010, 32'h1, 4'hF);
      bus_write(16'h0014, 32'h1, 4'hF);
      bus_write(16'h0018, 32'h1, 4'hF);
      check("R5 dec/byp/ksize", {29'b0, decrypt_en, bypass_en, key_size}, 32'h7);
      for (int k = 0; k < 8; k++) bus_write(16'h0020 + 16'(4*k), 32'hA000_0000 + k, 4'hF);
      check("R5 key word 0 lowest", key_out[31:0], 32'hA000_0000);
      check("R5 key word 7", key_out[255:224], 32'hA000_0007);
      for (int v = 0; v < 3; v++) bus_write(16'h0040 + 16'(4*v), 32'hB000_0010 + v, 4'hF);
      check("R5 iv word 2", iv_out[95:64], 32'hB000_0012);
      bus_read("R5 readback", 16'h0000, d);
      check("R5 in_base readback", d, 32'h0000_07F0);
      bus_read("R5 readback", 16'h0024, d);
      check("R5 key word 1 readback", d, 32'hA000_0001);
      bus_read("R5 readback", 16'h0018, d);
      check("R5 key size readback", d, 32'h1);
   endtask

   task automatic t_start_busy();
      logic [31:0] d;
      bus_write(16'h000C, 32'hFFFF_0040, 4'hF);
      check("R6 start pulse high", {31'b0, start}, 32'd1);
      check("R6 data_len stored", {16'b0, data_len}, 32'h40);
      @(negedge clk);
      check("R6 start pulse ends", {31'b0, start}, 32'd0);
      busy = 1'b1;
      bus_read("R7 status", 16'h000C, d);
      check("R7 busy only", d, 32'h1);
      key_busy = 1'b1; busy = 1'b0;
      bus_read("R7 status", 16'h000C, d);
      check("R7 key busy only", d, 32'h2);
      key_busy = 1'b0;
   endtask

   task automatic t_keyload();
      logic [31:0] d;
      bus_write(16'h001C, 32'hFFFF_FFFF, 4'hF);
      check("R8 key_load high", {31'b0, key_load}, 32'd1);
      @(negedge clk);
      check("R8 key_load ends", {31'b0, key_load}, 32'd0);
      bus_read("R8 readback", 16'h001C, d);
      check("R8 reads zero", d, 32'h0);
   endtask

   task automatic t_tag_version();
      logic [31:0] d;
      @(negedge clk);
      tag_in = 128'h4444_4444_3333_3333_2222_2222_1111_1111; tag_valid = 1'b1;
      @(negedge clk);
      tag_valid = 1'b0; tag_in = '0;
      bus_read("R9 tag", 16'h0050, d);
      check("R9 tag word 0", d, 32'h1111_1111);
      bus_read("R9 tag", 16'h005C, d);
      check("R9 tag word 3", d, 32'h4444_4444);
      bus_read("R10 version", 16'h0060, d);
      check("R10 version word", d, 32'h0002_0100);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      bus_write(16'h004C, 32'hDEAD_BEEF, 4'hF);
      bus_write(16'h0070, 32'hDEAD_BEEF, 4'hF);
      check("R11 key unchanged", key_out[31:0], 32'hA000_0000);
      check("R11 iv unchanged", iv_out[31:0], 32'hB000_0010);
      check("R11 lengths unchanged", {aad_len, data_len}, 32'h0123_0040);
      check("R11 no pulse", {30'b0, start, key_load}, 32'd0);
      bus_read("R11 unmapped", 16'h004C, d);
      check("R11 unmapped reads zero", d, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      for (int i = 0; i < 512; i++) begin in_ram[i] = '0; out_ram[i] = '0; end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_areas();
      t_bytes();
      t_params();
      t_start_busy();
      t_keyload();
      t_tag_version();
      t_unmapped();
      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule